// File: doc/BRIEF.md
# Synchronous Serial Byte Channel

This block moves one byte at a time over a three-wire synchronous link: a shift clock, a data line and a ready/handshake line. A processor reaches it through a two-location register window. Location 0 is a control/status byte and location 1 is a one-byte transceiver buffer. Two control bits place the channel in one of four roles: master transmitter, master receiver, slave transmitter or slave receiver. As master it makes the shift clock from the system clock with a divider set by a parameter. As slave it synchronizes the incoming shift clock and reacts to its edges.

Each byte goes out MSB first. Bits are launched on the falling shift-clock edge and sampled on the rising edge, and the clock idles high. A transfer-enable bit allows one byte and then clears itself, unless the auto-re-enable bit keeps it set. A read-only status bit reports the buffer state, and its sense depends on the direction. A sticky error bit records buffer accesses made while a byte is shifting. In slave mode it also records bytes that the remote master clocked before the buffer was ready.

Top module: `sscc_channel`

## Requirements
- R1: After reset, the control location reads 0x00, `sclk_out` is 1, `sclk_oe` is 0 and `hs_out` is 0.
- R2: Control bit layout: bit 7 master (1) / slave (0), bit 6 transmit (1) / receive (0), bit 5 spare read/write storage, bit 4 handshake enable, bit 3 transfer enable, bit 2 auto-re-enable, bit 1 error flag, bit 0 buffer status. Bits 7..2 read back as written, and writes to bit 0 have no effect.
- R3: As master with a byte pending, the channel produces 8 clock pulses starting from the idle-high level. Each half period lasts HALF_DIV system clocks. `sd_out` presents the buffer MSB first, and each bit changes on a falling edge.
- R4: As master receiver, the 8 bits on `sd_in` sampled at the rising edges are stored MSB first in the buffer, and the status bit reads 1.
- R5: At the end of each completed byte, the transfer-enable bit clears when auto-re-enable is 0 and stays set when it is 1. With it set, the next byte starts with no control write.
- R6: The status bit reads 1 for transmit with an empty buffer or receive with a full buffer, and 0 otherwise. A buffer write in transmit mode fills the buffer. A buffer read in receive mode empties it.
- R7: A read or write of the buffer while a byte is shifting sets the error flag. Such a write does not change the byte being sent.
- R8: The error flag stays set until a control write with bit 1 = 0. A control write with bit 1 = 1 leaves it set.
- R9: As slave, the channel shifts one byte on the edges of `sclk_in`. It receives into the buffer, or transmits the buffer MSB first on `sd_out`.
- R10: As slave, a byte clocked by the remote master while transfer is disabled or the buffer is not ready sets the error flag and is discarded, and the buffer keeps its contents.
- R11: With handshake, transfer enable and auto-re-enable all set, a master waits for `hs_in` = 1 before clocking. A slave drives `hs_out` = 1 only when it is idle and its buffer is ready.
- R12: A master produces no shift-clock edge while transfer is disabled or no byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 1 | 0 = control/status, 1 = buffer |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed location |
| sclk_in | input | 1 | Shift clock from a remote master |
| sclk_out | output | 1 | Shift clock produced as master (idles high) |
| sclk_oe | output | 1 | High when this channel drives the shift clock |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| hs_in | input | 1 | Remote-ready handshake input |
| hs_out | output | 1 | Local-ready handshake output |

## Verification
The bench tests transfer-enable self-clearing against auto-re-enable. A design that got this wrong would stall after the first byte or run on without being re-armed. It writes the buffer in the middle of a byte, where a faulty channel would send corrupted data or miss the error. It clocks a slave whose buffer is empty or still full, where a faulty slave would overwrite an unread byte or return stale data without flagging it. It checks the handshake gate, where a faulty master would clock before its peer is ready, and it checks the status bit in both directions, where a faulty design would report the wrong sense of the buffer state.

// File: rtl/sscc_pkg.sv
`timescale 1ns/1ps
package sscc_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 3;

  typedef struct packed {
    logic master;
    logic tx;
    logic spare;
    logic hs_en;
    logic xfer_en;
    logic auto_re;
    logic err;
    logic stat;
  } ctl_t;

  // a byte can be moved: something to send, or room to receive
  function automatic logic buf_ready(input logic tx, input logic full);
    return tx ? full : ~full;
  endfunction

  // status sense flips with direction
  function automatic logic status_bit(input logic tx, input logic full);
    return tx ? ~full : full;
  endfunction

  function automatic logic hs_mode(input ctl_t c);
    return c.hs_en & c.xfer_en & c.auto_re;
  endfunction
endpackage

// File: rtl/sscc_sync.sv
`timescale 1ns/1ps
module sscc_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST_VAL[i]}};
      else        st <= {st[0], d[i]};
    end
    assign q[i] = st[1];
  end
endmodule

// File: rtl/sscc_clkgen.sv
`timescale 1ns/1ps
module sscc_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall_ev,
  output logic rise_ev
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          sclk_q;
  logic          tick;

  assign tick = run && (div_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  assign sclk    = sclk_q;
  assign fall_ev = tick && sclk_q;
  assign rise_ev = tick && !sclk_q;
endmodule

// File: rtl/sscc_shifter.sv
`timescale 1ns/1ps
module sscc_shifter
  import sscc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              last_rise,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [BYTE_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (load) begin
        sr_q  <= load_val;
        cnt_q <= '0;
      end else if (rise_ev) begin
        sr_q  <= {sr_q[BYTE_W-2:0], sd_in};
        cnt_q <= cnt_q + 1'b1;
      end
      if (fall_ev) out_q <= load ? load_val[BYTE_W-1] : sr_q[BYTE_W-1];
    end
  end

  assign sd_out    = out_q;
  assign last_rise = rise_ev && (cnt_q == CNT_W'(BYTE_W - 1));
  assign rx_byte   = {sr_q[BYTE_W-2:0], sd_in};
endmodule

// File: rtl/sscc_channel.sv
`timescale 1ns/1ps
module sscc_channel
  import sscc_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic       cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic       sclk_in,
  output logic       sclk_out,
  output logic       sclk_oe,
  input  logic       sd_in,
  output logic       sd_out,
  input  logic       hs_in,
  output logic       hs_out
);
  ctl_t              ctl_q, ctl_n, ctl_rd;
  logic [BYTE_W-1:0] buf_q;
  logic              full_q, busy_q, discard_q, sclk_d;

  logic [2:0] sync_q;
  logic       sclk_s, sd_s, hs_s;
  sscc_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk_in, sd_in, hs_in}), .q(sync_q));
  assign {sclk_s, sd_s, hs_s} = sync_q;

  // named events for the checker
  logic m_sclk, m_fall, m_rise, s_fall, s_rise;
  logic fall_ev, rise_ev, last_rise, done_ev;
  logic avail, m_start, s_start, s_bad, start_ev;
  logic ctl_wr, buf_acc, err_set;
  logic [BYTE_W-1:0] rx_byte;

  sscc_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.master && busy_q),
    .sclk(m_sclk), .fall_ev(m_fall), .rise_ev(m_rise));

  assign s_fall  = !ctl_q.master && sclk_d && !sclk_s;
  assign s_rise  = !ctl_q.master && !sclk_d && sclk_s;
  assign fall_ev = ctl_q.master ? m_fall : s_fall;
  assign rise_ev = ctl_q.master ? m_rise : s_rise;

  assign avail   = buf_ready(ctl_q.tx, full_q);
  assign m_start = ctl_q.master && !busy_q && ctl_q.xfer_en && avail &&
                   (!hs_mode(ctl_q) || hs_s);
  assign s_start = !ctl_q.master && !busy_q && s_fall;
  assign s_bad   = s_start && !(ctl_q.xfer_en && avail);
  assign start_ev = m_start || s_start;
  assign done_ev = last_rise && busy_q && !discard_q;

  sscc_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(start_ev), .load_val(buf_q),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .sd_in(sd_s),
    .sd_out(sd_out), .last_rise(last_rise), .rx_byte(rx_byte));

  assign ctl_wr  = cpu_wr && !cpu_addr;
  assign buf_acc = (cpu_wr || cpu_rd) && cpu_addr;
  assign err_set = (buf_acc && busy_q) || s_bad;

  always_comb begin
    ctl_n = ctl_q;
    if (ctl_wr) begin
      ctl_n.master  = cpu_wdata[7];
      ctl_n.tx      = cpu_wdata[6];
      ctl_n.spare   = cpu_wdata[5];
      ctl_n.hs_en   = cpu_wdata[4];
      ctl_n.xfer_en = cpu_wdata[3];
      ctl_n.auto_re = cpu_wdata[2];
      if (!cpu_wdata[1]) ctl_n.err = 1'b0;
    end else if (done_ev && !ctl_q.auto_re) begin
      ctl_n.xfer_en = 1'b0;
    end
    if (err_set) ctl_n.err = 1'b1;
    ctl_n.stat = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      buf_q     <= '0;
      full_q    <= 1'b0;
      busy_q    <= 1'b0;
      discard_q <= 1'b0;
      sclk_d    <= 1'b1;
    end else begin
      ctl_q  <= ctl_n;
      sclk_d <= sclk_s;
      if (start_ev) begin
        busy_q    <= 1'b1;
        discard_q <= s_bad;
      end else if (last_rise) begin
        busy_q    <= 1'b0;
        discard_q <= 1'b0;
      end
      if (done_ev) begin
        if (ctl_q.tx) full_q <= 1'b0;
        else begin
          buf_q  <= rx_byte;
          full_q <= 1'b1;
        end
      end else if (buf_acc && !busy_q) begin
        if (cpu_wr) begin
          buf_q <= cpu_wdata;
          if (ctl_q.tx) full_q <= 1'b1;
        end else if (!ctl_q.tx) begin
          full_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    ctl_rd      = ctl_q;
    ctl_rd.stat = status_bit(ctl_q.tx, full_q);
  end

  assign cpu_rdata = cpu_addr ? buf_q : ctl_rd;
  assign sclk_out  = ctl_q.master ? m_sclk : 1'b1;
  assign sclk_oe   = ctl_q.master;
  assign hs_out    = !ctl_q.master && hs_mode(ctl_q) && !busy_q && avail;
endmodule

// File: rtl/sscc_checker.sv
`timescale 1ns/1ps
module sscc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_wr,
  input logic       cpu_rd,
  input logic       cpu_addr,
  input logic [7:0] cpu_wdata,
  input logic       sclk_out,
  input logic       busy,
  input logic       fall_ev,
  input logic       rise_ev,
  input logic       done_ev,
  input logic [7:0] ctl
);
  assert_edges_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_ev, fall_ev}));

  assert_idle_clock_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_out);

  assert_err_on_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cpu_wr || cpu_rd) && cpu_addr |=> ctl[1]);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[1] && !(cpu_wr && !cpu_addr && !cpu_wdata[1]) |=> ctl[1]);

  assert_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev && !ctl[2] && !(cpu_wr && !cpu_addr) |=> !ctl[3]);

  assert_rearm_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev && ctl[2] && !(cpu_wr && !cpu_addr) |=> ctl[3]);
endmodule

bind sscc_channel sscc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .sclk_out(sclk_out),
  .busy(busy_q), .fall_ev(fall_ev), .rise_ev(rise_ev), .done_ev(done_ev),
  .ctl(ctl_q));

// File: tb/sscc_channel_bench.sv
`timescale 1ns/1ps
module sscc_channel_bench;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_addr = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic sclk_in = 1'b1, sclk_out, sclk_oe, sd_in = 1'b0, sd_out;
  logic hs_in = 1'b0, hs_out;
  int checks = 0, errors = 0, falls = 0;

  always #2 clk = ~clk;
  always @(negedge sclk_out) falls++;

  sscc_channel #(.HALF_DIV(HALF)) u_sscc_channel (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sd_in(sd_in), .sd_out(sd_out), .hs_in(hs_in), .hs_out(hs_out));

  function automatic logic [7:0] cw(bit m, bit t, bit h, bit x, bit a, bit e, bit s);
    return {m, t, 1'b0, h, x, a, e, s};
  endfunction
  function automatic bit stat(bit tx, bit full);
    return tx ? !full : full;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask
  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1; #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  // peer of a master channel: feeds sd_in, records sd_out, measures half period
  task automatic peer(input logic [7:0] feed, output logic [7:0] seen, output int half_ns);
    time t0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge sclk_out); t0 = $time; #1 sd_in = feed[i];
      @(posedge sclk_out); #1 seen[i] = sd_out;
      if (i == 7) half_ns = int'($time - t0) - 1;
    end
  endtask

  // remote master driving a slave channel
  task automatic drive(input logic [7:0] din, output logic [7:0] dout);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sclk_in = 1'b0; sd_in = din[i];
      repeat (8) @(negedge clk);
      dout[i] = sd_out; sclk_in = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] d, b, r, seen;
    int half, f0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, d); chk("R1 ctl", d, 8'h00);
    chk("R1 sclk_out", sclk_out, 1); chk("R1 sclk_oe", sclk_oe, 0); chk("R1 hs_out", hs_out, 0);

    // R2 layout and read-only status, R6 receive-empty
    wr(0, 8'h24); rd(0, d); chk("R2 readback", d, 8'h24);
    wr(0, 8'h25); rd(0, d); chk("R2 bit0 ro", d, 8'h24);
    chk("R6 rx empty", d[0], stat(0, 0));

    // R12 enabled master transmitter with nothing pending: no clock
    f0 = falls; wr(0, cw(1,1,0,1,0,0,0));
    repeat (40) @(negedge clk); chk("R12 idle no clock", falls - f0, 0);
    rd(0, d); chk("R6 tx empty", d, cw(1,1,0,1,0,0,stat(1,0)));

    // R3/R5 master transmit, random bytes, self-clearing enable
    for (int k = 0; k < 4; k++) begin
      b = 8'($urandom); r = 8'($urandom);
      wr(0, cw(1,1,0,1,0,0,0));
      fork peer(r, seen, half); wr(1, b); join
      chk("R3 tx byte", seen, b);
      chk("R3 half period", half, HALF * 4);
      repeat (3) @(negedge clk);
      rd(0, d); chk("R5 self clear", d, cw(1,1,0,0,0,0,stat(1,0)));
    end
    f0 = falls; repeat (40) @(negedge clk); chk("R12 disabled no clock", falls - f0, 0);

    // R4 master receive
    r = 8'($urandom);
    fork peer(r, seen, half); wr(0, cw(1,0,0,1,0,0,0)); join
    repeat (3) @(negedge clk);
    rd(0, d); chk("R4 rx status", d, cw(1,0,0,0,0,0,stat(0,1)));
    rd(1, d); chk("R4 rx byte", d, r);
    rd(0, d); chk("R6 rx read empties", d[0], stat(0, 0));

    // R5 auto re-enable: two bytes with no control rewrite
    wr(0, cw(1,1,0,1,1,0,0));
    for (int k = 0; k < 2; k++) begin
      b = 8'($urandom);
      fork peer(8'h5A, seen, half); wr(1, b); join
      chk("R5 auto byte", seen, b);
      repeat (3) @(negedge clk);
      rd(0, d); chk("R5 enable kept", d, cw(1,1,0,1,1,0,stat(1,0)));
    end

    // R7 buffer write during shift: error, byte intact
    b = 8'hC3;
    fork
      peer(8'h00, seen, half);
      begin
        wr(1, b);
        @(negedge sclk_out); repeat (2) @(negedge clk); wr(1, ~b);
      end
    join
    chk("R7 byte intact", seen, b);
    repeat (3) @(negedge clk);
    rd(0, d); chk("R7 error set", d, cw(1,1,0,1,1,1,stat(1,0)));

    // R8 sticky error
    wr(0, cw(1,1,0,1,1,1,0)); rd(0, d); chk("R8 write 1 keeps", d[1], 1);
    wr(0, cw(1,1,0,1,1,0,0)); rd(0, d); chk("R8 write 0 clears", d[1], 0);

    // R9 slave receive and transmit
    r = 8'($urandom);
    wr(0, cw(0,0,0,1,0,0,0)); drive(r, seen);
    rd(0, d); chk("R9 slave rx status", d, cw(0,0,0,0,0,0,stat(0,1)));
    rd(1, d); chk("R9 slave rx byte", d, r);
    b = 8'($urandom);
    wr(0, cw(0,1,0,1,0,0,0)); wr(1, b);
    rd(0, d); chk("R6 tx full", d[0], stat(1, 1));
    drive(8'hFF, seen); chk("R9 slave tx byte", seen, b);
    rd(0, d); chk("R9 slave tx done", d, cw(0,1,0,0,0,0,stat(1,0)));

    // R10 slave clocked while not ready
    wr(0, cw(0,1,0,1,0,0,0)); drive(8'h00, seen);
    rd(0, d); chk("R10 tx underflow", d, cw(0,1,0,1,0,1,stat(1,0)));
    r = 8'($urandom);
    wr(0, cw(0,0,0,1,0,0,0)); drive(r, seen);
    drive(~r, seen);
    rd(0, d); chk("R10 rx overflow", d, cw(0,0,0,0,0,1,stat(0,1)));
    rd(1, d); chk("R10 buffer kept", d, r);

    // R11 handshake, master side
    wr(0, cw(1,1,1,1,1,0,0));
    b = 8'($urandom); f0 = falls; wr(1, b);
    repeat (40) @(negedge clk); chk("R11 master waits", falls - f0, 0);
    fork peer(8'h00, seen, half); begin @(negedge clk); hs_in = 1'b1; end join
    chk("R11 master byte", seen, b);
    hs_in = 1'b0;

    // R11 handshake, slave side
    wr(0, cw(0,0,1,1,1,0,0)); @(negedge clk);
    chk("R11 slave ready", hs_out, 1);
    r = 8'($urandom); drive(r, seen);
    chk("R11 slave full not ready", hs_out, 0);
    rd(1, d); chk("R11 slave byte", d, r);
    @(negedge clk); chk("R11 slave ready again", hs_out, 1);

    finish_run();
  end
endmodule